// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Core

This block is the acceptance stage of a local interrupt controller for a 256-vector space. It keeps three 256-bit state arrays: requested vectors, vectors in service, and a per-vector level/edge flag. It finds the most urgent request and decides whether that request can interrupt the processor. The decision compares the 16-vector class of the request (the upper nibble of the vector number) with a processor priority. The processor priority is formed from a task priority input and the most urgent vector currently in service.

Requests enter through a raise strobe that carries a vector number and a trigger kind. The processor side takes the most urgent deliverable vector with an acknowledge strobe and retires it with an end-of-interrupt strobe. When a retired vector was level triggered, the block emits a broadcast pulse so that upstream sources can re-sample their lines. A small configuration register, written through a single strobe, holds a software enable, a directed end-of-interrupt switch and the vector returned for spurious acknowledges.

Top module: `vic_core`

## Requirements
- R1: Among requested vectors the most urgent is the highest-numbered one; an acknowledge of a deliverable request returns that vector on `ack_vec` with `ack_vld` high in the cycle after the strobe, clears its request bit and sets its in-service bit.
- R2: A raise with `raise_level`=1 marks the vector level triggered; a raise with `raise_level`=0 marks it edge triggered, replacing any earlier marking of that vector.
- R3: While the software-enable bit (bit 8 of the configuration register) is 0, `irq_pending` stays low whatever is requested.
- R4: A request is blocked when the processor priority is nonzero and the request's upper nibble is less than or equal to the processor priority's upper nibble; `irq_pending` is high only for an unblocked request with software enable set.
- R5: An acknowledge when no deliverable request exists returns bits [7:0] of the configuration register and changes neither the request nor the in-service array.
- R6: An end-of-interrupt clears the highest set in-service bit; if that vector is level triggered and the directed bit (bit 12 of the configuration register) is 0, `eoi_bc_vld` pulses for one cycle in the cycle after the strobe with the vector on `eoi_bc_vec`.
- R7: A configuration write keeps bits [8:0] and bit 12 of `cfg_wdata` and clears all other bits; `cfg_value` shows the stored register one cycle after the write.
- R8: The processor priority equals the task priority when no vector is in service or when the task priority's upper nibble is at least the upper nibble of the highest in-service vector; otherwise it is that vector's upper nibble with a zero low nibble.
- R9: An end-of-interrupt with nothing in service changes no state and produces no broadcast.
- R10: `irq_pending` is a combinational function of the stored arrays, the configuration register and `tpr`, so it reflects a state change in the same cycle that state is updated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_vld | input | 1 | Request a vector this cycle |
| raise_vec | input | 8 | Vector number to request |
| raise_level | input | 1 | 1 = level triggered, 0 = edge triggered |
| tpr | input | 8 | Task priority value |
| ack_req | input | 1 | Acknowledge strobe |
| eoi_req | input | 1 | End-of-interrupt strobe |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| irq_pending | output | 1 | A deliverable request exists |
| ack_vld | output | 1 | Acknowledge result valid |
| ack_vec | output | 8 | Acknowledged or spurious vector |
| eoi_bc_vld | output | 1 | End-of-interrupt broadcast pulse |
| eoi_bc_vec | output | 8 | Vector carried by the broadcast |
| cfg_value | output | 32 | Stored configuration register |

## Verification
On every cycle the assertions check the configuration masking, that a level raise leaves the vector marked level, that acknowledge and broadcast pulses only follow their strobes, that a broadcast never appears with the directed bit set, and that a blocked acknowledge returns the spurious vector. The ordering of vectors across words, the class comparison against the task priority at its boundaries, the rise of the processor priority from an in-service vector and its fall after retirement, and the sequence of nested acknowledges and retirements can only be shown by the bench's directed scenarios.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int unsigned NUM_VEC  = 256;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned NUM_WORD = NUM_VEC / WORD_W;
    localparam int unsigned VEC_W    = $clog2(NUM_VEC);
    localparam int unsigned CFG_W    = 32;

    localparam int unsigned CFG_EN_BIT  = 8;
    localparam int unsigned CFG_DIR_BIT = 12;
    localparam logic [CFG_W-1:0] CFG_KEEP = 32'h0000_11FF;

    typedef struct packed {
        logic [NUM_VEC-1:0] req;
        logic [NUM_VEC-1:0] svc;
        logic [NUM_VEC-1:0] lvl;
        logic [CFG_W-1:0]   cfg;
        logic               ack_vld;
        logic [VEC_W-1:0]   ack_vec;
        logic               bc_vld;
        logic [VEC_W-1:0]   bc_vec;
    } vic_state_t;
endpackage

// File: rtl/vic_msb_find.sv
module vic_msb_find #(
    parameter int unsigned W  = 32,
    parameter int unsigned IW = $clog2(W)
) (
    input  logic [W-1:0]  bits,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |bits;
        idx   = '0;
        for (int i = 0; i < W; i++) begin
            if (bits[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/vic_vec_search.sv
module vic_vec_search
    import vic_pkg::*;
(
    input  logic [NUM_VEC-1:0] vec,
    output logic               found,
    output logic [VEC_W-1:0]   top
);
    localparam int unsigned BW = $clog2(WORD_W);
    localparam int unsigned WW = $clog2(NUM_WORD);

    logic [NUM_WORD-1:0] word_any;
    logic [BW-1:0]       word_top [NUM_WORD];
    logic [WW-1:0]       sel_word;

    for (genvar g = 0; g < NUM_WORD; g++) begin : g_word
        vic_msb_find #(.W(WORD_W), .IW(BW)) u_word (
            .bits  (vec[g*WORD_W +: WORD_W]),
            .found (word_any[g]),
            .idx   (word_top[g])
        );
    end

    vic_msb_find #(.W(NUM_WORD), .IW(WW)) u_outer (
        .bits  (word_any),
        .found (found),
        .idx   (sel_word)
    );

    assign top = {sel_word, word_top[sel_word]};
endmodule

// File: rtl/vic_ppr.sv
module vic_ppr
    import vic_pkg::*;
(
    input  logic [VEC_W-1:0] tpr,
    input  logic             svc_found,
    input  logic [VEC_W-1:0] svc_top,
    output logic [VEC_W-1:0] ppr
);
    always_comb begin
        if (!svc_found || tpr[VEC_W-1:4] >= svc_top[VEC_W-1:4]) begin
            ppr = tpr;
        end else begin
            ppr = {svc_top[VEC_W-1:4], 4'h0};
        end
    end
endmodule

// File: rtl/vic_core.sv
module vic_core
    import vic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raise_vld,
    input  logic [7:0]       raise_vec,
    input  logic             raise_level,
    input  logic [7:0]       tpr,
    input  logic             ack_req,
    input  logic             eoi_req,
    input  logic             cfg_we,
    input  logic [31:0]      cfg_wdata,
    output logic             irq_pending,
    output logic             ack_vld,
    output logic [7:0]       ack_vec,
    output logic             eoi_bc_vld,
    output logic [7:0]       eoi_bc_vec,
    output logic [31:0]      cfg_value
);
    vic_state_t st_q, st_d;

    logic             req_found, svc_found;
    logic [VEC_W-1:0] req_top, svc_top, ppr;
    logic             blocked;

    vic_vec_search u_req_search (.vec(st_q.req), .found(req_found), .top(req_top));
    vic_vec_search u_svc_search (.vec(st_q.svc), .found(svc_found), .top(svc_top));

    vic_ppr u_ppr (
        .tpr       (tpr),
        .svc_found (svc_found),
        .svc_top   (svc_top),
        .ppr       (ppr)
    );

    // class comparison: request class against processor priority class
    assign blocked     = (ppr != '0) && (req_top[VEC_W-1:4] <= ppr[VEC_W-1:4]);
    assign irq_pending = st_q.cfg[CFG_EN_BIT] && req_found && !blocked;

    always_comb begin
        st_d         = st_q;
        st_d.ack_vld = 1'b0;
        st_d.bc_vld  = 1'b0;

        // retirement of the most urgent in-service vector
        if (eoi_req && svc_found) begin
            st_d.svc[svc_top] = 1'b0;
            if (st_q.lvl[svc_top] && !st_q.cfg[CFG_DIR_BIT]) begin
                st_d.bc_vld = 1'b1;
                st_d.bc_vec = svc_top;
            end
        end

        // acknowledge: move request to service, or answer spurious
        if (ack_req) begin
            st_d.ack_vld = 1'b1;
            if (irq_pending) begin
                st_d.req[req_top] = 1'b0;
                st_d.svc[req_top] = 1'b1;
                st_d.ack_vec      = req_top;
            end else begin
                st_d.ack_vec = st_q.cfg[VEC_W-1:0];
            end
        end

        // new request wins over a same-cycle acknowledge clear
        if (raise_vld) begin
            st_d.req[raise_vec] = 1'b1;
            st_d.lvl[raise_vec] = raise_level;
        end

        if (cfg_we) begin
            st_d.cfg = cfg_wdata & CFG_KEEP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_vld    = st_q.ack_vld;
    assign ack_vec    = st_q.ack_vec;
    assign eoi_bc_vld = st_q.bc_vld;
    assign eoi_bc_vec = st_q.bc_vec;
    assign cfg_value  = st_q.cfg;

    // R7: only the kept configuration fields survive a write
    p_cfg_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_value == ($past(cfg_wdata) & CFG_KEEP));

    // R2: a level raise leaves the vector marked level
    p_level_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_vld && raise_level) |=> st_q.lvl[$past(raise_vec)]);

    // R1: acknowledge result follows its strobe
    p_ack_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld |-> $past(ack_req));

    // R5: an undeliverable acknowledge returns the spurious vector
    p_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !irq_pending) |=> ack_vec == $past(cfg_value[7:0]));

    // R6: broadcast only after a retirement with the directed bit clear
    p_bc_rule_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_bc_vld |-> ($past(eoi_req) && !$past(cfg_value[CFG_DIR_BIT])));

    // R3: software disable silences the pending line
    p_disable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_value[CFG_EN_BIT] |-> !irq_pending);
endmodule

// File: tb/vic_core_tb.sv
module vic_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        raise_vld = 1'b0;
    logic [7:0]  raise_vec = '0;
    logic        raise_level = 1'b0;
    logic [7:0]  tpr = '0;
    logic        ack_req = 1'b0;
    logic        eoi_req = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        irq_pending, ack_vld, eoi_bc_vld;
    logic [7:0]  ack_vec, eoi_bc_vec;
    logic [31:0] cfg_value;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    vic_core u_dut (
        .clk(clk), .rst_n(rst_n),
        .raise_vld(raise_vld), .raise_vec(raise_vec), .raise_level(raise_level),
        .tpr(tpr), .ack_req(ack_req), .eoi_req(eoi_req),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .irq_pending(irq_pending), .ack_vld(ack_vld), .ack_vec(ack_vec),
        .eoi_bc_vld(eoi_bc_vld), .eoi_bc_vec(eoi_bc_vec), .cfg_value(cfg_value)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic raise(logic [7:0] v, logic lvl);
        @(negedge clk);
        raise_vld = 1'b1; raise_vec = v; raise_level = lvl;
        @(negedge clk);
        raise_vld = 1'b0;
    endtask

    task automatic write_cfg(logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_ack(string req, logic [7:0] exp);
        @(negedge clk);
        ack_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
        check(req, {31'd0, ack_vld}, 32'd1);
        check(req, {24'd0, ack_vec}, {24'd0, exp});
    endtask

    task automatic do_eoi(string req, logic exp_bc, logic [7:0] exp_vec);
        @(negedge clk);
        eoi_req = 1'b1;
        @(negedge clk);
        eoi_req = 1'b0;
        check(req, {31'd0, eoi_bc_vld}, {31'd0, exp_bc});
        if (exp_bc) check(req, {24'd0, eoi_bc_vec}, {24'd0, exp_vec});
    endtask

    task automatic t_reset();
        check("R3 reset pending", {31'd0, irq_pending}, 0);
        check("R1 reset ack", {31'd0, ack_vld}, 0);
        check("R6 reset bc", {31'd0, eoi_bc_vld}, 0);
        check("R7 reset cfg", cfg_value, 0);
    endtask

    task automatic t_disabled();
        raise(8'h40, 1'b0);
        check("R3 disabled pending", {31'd0, irq_pending}, 0);
        do_ack("R5 ack while disabled", 8'h00);
    endtask

    task automatic t_cfg_mask();
        write_cfg(32'hFFFF_FFFF);
        check("R7 masked write", cfg_value, 32'h0000_11FF);
        write_cfg(32'h0000_01FF);
        check("R7 plain write", cfg_value, 32'h0000_01FF);
        check("R10 pending after enable", {31'd0, irq_pending}, 1);
    endtask

    task automatic t_nesting();
        do_ack("R1 first ack", 8'h40);
        check("R10 pending cleared", {31'd0, irq_pending}, 0);
        raise(8'h21, 1'b0);
        raise(8'h9F, 1'b0);
        raise(8'h95, 1'b0);
        check("R8 higher class pending", {31'd0, irq_pending}, 1);
        do_ack("R1 highest word first", 8'h9F);
        check("R8 same class blocked", {31'd0, irq_pending}, 0);
        do_ack("R5 spurious on blocked", 8'hFF);
        do_eoi("R6 edge retire", 1'b0, 8'h00);
        check("R8 priority falls", {31'd0, irq_pending}, 1);
        do_ack("R1 second in class", 8'h95);
        do_eoi("R6 retire 95", 1'b0, 8'h00);
        check("R8 class 4 blocks 21", {31'd0, irq_pending}, 0);
        do_eoi("R6 retire 40", 1'b0, 8'h00);
        check("R8 empty service uses tpr", {31'd0, irq_pending}, 1);
    endtask

    task automatic t_tpr();
        tpr = 8'h30; #1;
        check("R4 tpr above class", {31'd0, irq_pending}, 0);
        tpr = 8'h2F; #1;
        check("R4 tpr equal class", {31'd0, irq_pending}, 0);
        tpr = 8'h1F; #1;
        check("R4 tpr below class", {31'd0, irq_pending}, 1);
        do_ack("R1 ack under tpr", 8'h21);
        tpr = 8'h00;
        raise(8'h05, 1'b0);
        tpr = 8'h01; #1;
        check("R4 nonzero ppr blocks class 0", {31'd0, irq_pending}, 0);
        do_eoi("R6 retire 21", 1'b0, 8'h00);
        check("R4 class 0 still blocked", {31'd0, irq_pending}, 0);
        tpr = 8'h00; #1;
        check("R4 zero ppr passes class 0", {31'd0, irq_pending}, 1);
        do_ack("R1 ack class 0", 8'h05);
        do_eoi("R6 retire 05", 1'b0, 8'h00);
    endtask

    task automatic t_level();
        raise(8'h60, 1'b1);
        do_ack("R1 ack level", 8'h60);
        do_eoi("R6 level broadcast", 1'b1, 8'h60);
        check("R6 broadcast one cycle", {31'd0, eoi_bc_vld}, 1);
        @(negedge clk);
        check("R6 broadcast ends", {31'd0, eoi_bc_vld}, 0);
        raise(8'h61, 1'b1);
        do_ack("R1 ack 61", 8'h61);
        write_cfg(32'h0000_11FF);
        do_eoi("R6 directed suppresses", 1'b0, 8'h00);
        write_cfg(32'h0000_01FF);
        raise(8'h70, 1'b1);
        raise(8'h70, 1'b0);
        do_ack("R2 ack 70", 8'h70);
        do_eoi("R2 edge rewrite no bc", 1'b0, 8'h00);
    endtask

    task automatic t_ppr_tpr_wins();
        raise(8'h50, 1'b1);
        do_ack("R8 ack 50", 8'h50);
        tpr = 8'h70;
        raise(8'h75, 1'b0);
        check("R8 tpr class dominates", {31'd0, irq_pending}, 0);
        raise(8'h80, 1'b0);
        check("R8 above tpr class", {31'd0, irq_pending}, 1);
        do_ack("R1 ack 80", 8'h80);
        do_eoi("R6 retire 80", 1'b0, 8'h00);
        do_eoi("R6 retire 50 level", 1'b1, 8'h50);
        tpr = 8'h00;
        do_ack("R1 ack 75", 8'h75);
        do_eoi("R6 retire 75", 1'b0, 8'h00);
        do_eoi("R9 empty eoi", 1'b0, 8'h00);
        check("R9 nothing pending", {31'd0, irq_pending}, 0);
        do_ack("R9 state unchanged", 8'hFF);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_cfg_mask();
        t_nesting();
        t_tpr();
        t_level();
        t_ppr_tpr_wins();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule